// File: doc/BRIEF.md
# Teleprinter Output Flag Controller

This block is the printer-side half of a console terminal port on a 12-bit accumulator machine. The processor issues an I/O transfer aimed at the printer device. The block then reads a 3-bit function field and acts on a single "printer ready" flag: it can set the flag, clear it, test it, or hand a character to an abstract character sink. The sink reports the end of each character with a done pulse, and that pulse sets the ready flag again.

Skip requests go straight to the program-counter logic in the same cycle as the function strobe. One test function looks only at the printer flag. The other skips when the printer flag or the separate keyboard flag is set. A character taken from the low accumulator bits is presented on a byte output, together with a one-cycle valid strobe. The serial line driver and the keyboard receiver are not part of this block.

Top module: `printer_flag_ctrl`

## Requirements
- R1: After synchronous reset, the ready flag is clear, `char_valid` is 0 and `char_byte` is 0. A flag test issued straight after reset does not skip.
- R2: Function code 0, strobed, sets the ready flag from the next cycle on.
- R3: Function code 1, strobed, drives `skip_req` high in the strobe cycle exactly when the ready flag is set.
- R4: Function code 2, strobed, clears the ready flag from the next cycle on, unless `sink_done` is high in the same cycle.
- R5: Function code 4, strobed, raises `char_valid` in the following cycle, with `char_byte` equal to `acc[7:0]` as sampled at the strobe. The ready flag is left unchanged.
- R6: Function code 5, strobed, drives `skip_req` high in the strobe cycle when the ready flag or `kbd_flag` is set.
- R7: Function code 6, strobed, prints exactly as code 4 does and also clears the ready flag, unless `sink_done` is high in the same cycle.
- R8: Function codes 3 and 7 change nothing. The flag keeps its value, `skip_req` stays low and no character is presented.
- R9: A `sink_done` pulse sets the ready flag from the next cycle on. When it coincides with a clearing function (code 2 or 6), the flag ends up set.
- R10: `skip_req` is low in every cycle where `func_stb` is low, whatever `func_code` and `kbd_flag` are. `char_valid` is high for exactly one cycle per print.
- R11: `char_byte` keeps the last printed character until the next print or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_stb | input | 1 | High for one cycle when a printer I/O transfer executes |
| func_code | input | 3 | Low three bits of the instruction word (function select) |
| acc | input | 12 | Accumulator value |
| kbd_flag | input | 1 | Keyboard input flag from the receiver side |
| sink_done | input | 1 | Character sink has finished the previous character |
| skip_req | output | 1 | Skip request to the program counter, valid in the strobe cycle |
| char_valid | output | 1 | One-cycle strobe: a new character is on `char_byte` |
| char_byte | output | 8 | Character to print (low accumulator byte) |

## Verification
The assertions take `func_stb` to be a single-cycle event and `func_code` to be stable in the cycle it is sampled. They place no restriction on `sink_done`, which may arrive at any time, including in the same cycle as a clearing function. The stimulus changes inputs only on the falling clock edge and holds each strobe for a single cycle. It deliberately drives `sink_done` together with codes 2 and 6, and it raises `kbd_flag` and a valid-looking `func_code` while the strobe is low. This exercises the set-wins priority and the strobe-only skip window.

// File: rtl/prn_pkg.sv
package prn_pkg;

    localparam int FUNC_W = 3;

    // Function select values; the numeric codes are fixed by the instruction set.
    typedef enum logic [FUNC_W-1:0] {
        FN_SET_RDY   = 3'd0,
        FN_TEST_RDY  = 3'd1,
        FN_CLR_RDY   = 3'd2,
        FN_IDLE_A    = 3'd3,
        FN_PRINT     = 3'd4,
        FN_TEST_ANY  = 3'd5,
        FN_PRINT_CLR = 3'd6,
        FN_IDLE_B    = 3'd7
    } prn_func_e;

    // One-hot-ish control word produced by the decoder.
    typedef struct packed {
        logic set_rdy;
        logic clr_rdy;
        logic test_rdy;
        logic test_any;
        logic print;
    } prn_ctl_t;

    function automatic prn_ctl_t decode_func(input logic stb, input prn_func_e code);
        prn_ctl_t c;
        c = '0;
        if (stb) begin
            case (code)
                FN_SET_RDY:   c.set_rdy  = 1'b1;
                FN_TEST_RDY:  c.test_rdy = 1'b1;
                FN_CLR_RDY:   c.clr_rdy  = 1'b1;
                FN_PRINT:     c.print    = 1'b1;
                FN_TEST_ANY:  c.test_any = 1'b1;
                FN_PRINT_CLR: begin
                    c.print   = 1'b1;
                    c.clr_rdy = 1'b1;
                end
                default:      c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/prn_func_decode.sv
module prn_func_decode
    import prn_pkg::*;
(
    input  logic              func_stb,
    input  logic [FUNC_W-1:0] func_code,
    output prn_ctl_t          ctl
);

    always_comb begin
        ctl = decode_func(func_stb, prn_func_e'(func_code));
    end

endmodule

// File: rtl/prn_ready_flag.sv
module prn_ready_flag #(
    parameter logic RESET_READY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_rdy,
    input  logic clr_rdy,
    input  logic sink_done,
    output logic ready
);

    // The done pulse and an explicit set share priority over any clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= RESET_READY;
        end else if (sink_done || set_rdy) begin
            ready <= 1'b1;
        end else if (clr_rdy) begin
            ready <= 1'b0;
        end
    end

endmodule

// File: rtl/prn_skip_eval.sv
module prn_skip_eval (
    input  logic test_rdy,
    input  logic test_any,
    input  logic ready,
    input  logic kbd_flag,
    output logic skip_req
);

    always_comb begin
        skip_req = (test_rdy && ready) || (test_any && (ready || kbd_flag));
    end

endmodule

// File: rtl/prn_char_latch.sv
module prn_char_latch #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              print,
    input  logic [CHAR_W-1:0] char_in,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_byte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            char_valid <= 1'b0;
            char_byte  <= '0;
        end else begin
            char_valid <= print;
            if (print) begin
                char_byte <= char_in;
            end
        end
    end

endmodule

// File: rtl/printer_flag_ctrl.sv
module printer_flag_ctrl
    import prn_pkg::*;
#(
    parameter int   ACC_W       = 12,
    parameter int   CHAR_W      = 8,
    parameter logic RESET_READY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              func_stb,
    input  logic [FUNC_W-1:0] func_code,
    input  logic [ACC_W-1:0]  acc,
    input  logic              kbd_flag,
    input  logic              sink_done,
    output logic              skip_req,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_byte
);

    localparam int PAD_W = (CHAR_W > ACC_W) ? (CHAR_W - ACC_W) : 1;

    prn_ctl_t          ctl;
    logic              ready_q;
    logic [CHAR_W-1:0] acc_lo;

    // Character source: low accumulator bits, zero-padded if the sink is wider.
    generate
        if (CHAR_W <= ACC_W) begin : g_slice
            assign acc_lo = acc[CHAR_W-1:0];
        end else begin : g_pad
            assign acc_lo = {{PAD_W{1'b0}}, acc};
        end
    endgenerate

    prn_func_decode i_decode (
        .func_stb  (func_stb),
        .func_code (func_code),
        .ctl       (ctl)
    );

    prn_ready_flag #(
        .RESET_READY (RESET_READY)
    ) i_flag (
        .clk       (clk),
        .rst       (rst),
        .set_rdy   (ctl.set_rdy),
        .clr_rdy   (ctl.clr_rdy),
        .sink_done (sink_done),
        .ready     (ready_q)
    );

    prn_skip_eval i_skip (
        .test_rdy (ctl.test_rdy),
        .test_any (ctl.test_any),
        .ready    (ready_q),
        .kbd_flag (kbd_flag),
        .skip_req (skip_req)
    );

    prn_char_latch #(
        .CHAR_W (CHAR_W)
    ) i_latch (
        .clk        (clk),
        .rst        (rst),
        .print      (ctl.print),
        .char_in    (acc_lo),
        .char_valid (char_valid),
        .char_byte  (char_byte)
    );

endmodule

// File: rtl/prn_flag_ctrl_chk.sv
module prn_flag_ctrl_chk #(
    parameter int ACC_W  = 12,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              func_stb,
    input logic [2:0]        func_code,
    input logic [ACC_W-1:0]  acc,
    input logic              kbd_flag,
    input logic              sink_done,
    input logic              skip_req,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_byte,
    input logic              ready_q
);

    logic is_print;
    assign is_print = func_stb && (func_code == 3'd4 || func_code == 3'd6);

    // R2
    a_r2_set_flag: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd0 |=> ready_q);

    // R3
    a_r3_test_flag: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd1 |-> skip_req == ready_q);

    // R4
    a_r4_clear_flag: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd2 && !sink_done |=> !ready_q);

    // R5
    a_r5_print_char: assert property (@(posedge clk) disable iff (rst)
        is_print |=> char_valid && char_byte == CHAR_W'($past(acc)));

    // R5
    a_r5_print_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd4 && !sink_done |=> ready_q == $past(ready_q));

    // R6
    a_r6_test_any: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd5 |-> skip_req == (ready_q || kbd_flag));

    // R7
    a_r7_print_clears: assert property (@(posedge clk) disable iff (rst)
        func_stb && func_code == 3'd6 && !sink_done |=> !ready_q);

    // R8
    a_r8_idle_codes: assert property (@(posedge clk) disable iff (rst)
        func_stb && (func_code == 3'd3 || func_code == 3'd7) && !sink_done
        |=> ready_q == $past(ready_q) && !char_valid);

    // R8
    a_r8_idle_no_skip: assert property (@(posedge clk) disable iff (rst)
        func_stb && (func_code == 3'd3 || func_code == 3'd7) |-> !skip_req);

    // R9
    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
        sink_done |=> ready_q);

    // R10
    a_r10_skip_window: assert property (@(posedge clk) disable iff (rst)
        !func_stb |-> !skip_req);

    // R10
    a_r10_valid_source: assert property (@(posedge clk) disable iff (rst)
        !is_print |=> !char_valid);

    // R11
    a_r11_hold_char: assert property (@(posedge clk) disable iff (rst)
        !is_print |=> $stable(char_byte));

endmodule

bind printer_flag_ctrl prn_flag_ctrl_chk #(
    .ACC_W  (ACC_W),
    .CHAR_W (CHAR_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .func_stb   (func_stb),
    .func_code  (func_code),
    .acc        (acc),
    .kbd_flag   (kbd_flag),
    .sink_done  (sink_done),
    .skip_req   (skip_req),
    .char_valid (char_valid),
    .char_byte  (char_byte),
    .ready_q    (ready_q)
);

// File: tb/test_printer_flag_ctrl.sv
module test_printer_flag_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    typedef struct packed {
        logic        stb;
        logic [2:0]  code;
        logic [11:0] acc;
        logic        kbd;
        logic        done;
        logic        exp_skip;
        logic        exp_print;
    } vec_t;

    // Walked in order from the reset state (ready flag clear).
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 0  R3 flag clear
        '{1'b1, 3'd5, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0},  // 1  R6 kbd only
        '{1'b1, 3'd5, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 2  R6 neither
        '{1'b1, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 3  R2 set
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 4  R3 set seen
        '{1'b1, 3'd3, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0},  // 5  R8 code 3
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 6  R8 flag kept
        '{1'b1, 3'd7, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0},  // 7  R8 code 7
        '{1'b1, 3'd4, 12'hEC1, 1'b0, 1'b0, 1'b0, 1'b1},  // 8  R5 print
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 9  R5 flag kept
        '{1'b1, 3'd6, 12'h5A7, 1'b0, 1'b0, 1'b0, 1'b1},  // 10 R7 print+clear
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 11 R7 cleared
        '{1'b0, 3'd0, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0},  // 12 R9 done
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 13 R9 set seen
        '{1'b1, 3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 14 R4 clear
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 15 R4 cleared
        '{1'b0, 3'd5, 12'h0FF, 1'b1, 1'b0, 1'b0, 1'b0},  // 16 R10 no strobe
        '{1'b1, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0},  // 17 set
        '{1'b1, 3'd2, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0},  // 18 R9 clear+done
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 19 R9 set wins
        '{1'b1, 3'd5, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // 20 R6 flag only
        '{1'b1, 3'd6, 12'h3FF, 1'b0, 1'b1, 1'b0, 1'b1},  // 21 R7/R9 print+done
        '{1'b1, 3'd1, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0}   // 22 R9 still set
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        func_stb = 1'b0;
    logic [2:0]  func_code = 3'd0;
    logic [11:0] acc = 12'h000;
    logic        kbd_flag = 1'b0;
    logic        sink_done = 1'b0;
    logic        skip_req;
    logic        char_valid;
    logic [7:0]  char_byte;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    printer_flag_ctrl i_printer_flag_ctrl (
        .clk        (clk),
        .rst        (rst),
        .func_stb   (func_stb),
        .func_code  (func_code),
        .acc        (acc),
        .kbd_flag   (kbd_flag),
        .sink_done  (sink_done),
        .skip_req   (skip_req),
        .char_valid (char_valid),
        .char_byte  (char_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        func_stb  = v.stb;
        func_code = v.code;
        acc       = v.acc;
        kbd_flag  = v.kbd;
        sink_done = v.done;
    endtask

    task automatic idle();
        func_stb  = 1'b0;
        func_code = 3'd0;
        acc       = 12'h000;
        kbd_flag  = 1'b0;
        sink_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic       prev_print;
        logic [7:0] exp_byte;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 char_valid", int'(char_valid), 0);
        chk("R1 char_byte", int'(char_byte), 0);
        func_stb  = 1'b1;
        func_code = 3'd1;
        #1;
        chk("R1 test after reset", int'(skip_req), 0);
        @(negedge clk);
        idle();

        prev_print = 1'b0;
        exp_byte   = 8'h00;
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("R10 valid step %0d", i), int'(char_valid), int'(prev_print));
            chk($sformatf("R11 byte step %0d", i), int'(char_byte), int'(exp_byte));
            drive(VECS[i]);
            #1;
            chk($sformatf("R3/R6/R8 skip step %0d", i), int'(skip_req), int'(VECS[i].exp_skip));
            prev_print = VECS[i].exp_print;
            if (VECS[i].exp_print) begin
                exp_byte = VECS[i].acc[7:0];
            end
            @(negedge clk);
            idle();
        end

        // R5/R7: last print visible, then R11 hold over idle cycles
        chk("R5 last valid", int'(char_valid), int'(prev_print));
        chk("R7 last byte", int'(char_byte), int'(exp_byte));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 single pulse", int'(char_valid), 0);
            chk("R11 hold byte", int'(char_byte), int'(exp_byte));
        end

        // R1: reset in mid-run clears the set flag and the byte
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 byte after reset", int'(char_byte), 0);
        func_stb  = 1'b1;
        func_code = 3'd1;
        #1;
        chk("R1 flag after reset", int'(skip_req), 0);
        @(negedge clk);
        idle();
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule